// File: doc/BRIEF.md
# Locking Four-Way DMA Request Prioritizer

This block sits between the DMA request strobes of two serial channels and a single bus-side arbiter. There are four request lines: receive and transmit for channel A and for channel B. Software sets an enable bit for each line. When the block is idle and at least one enabled line is asserted, the block latches one winner by fixed priority and raises one merged request. It also presents a 2-bit code, which the arbiter uses to pick one of four stored arbitration vectors. The winner stays latched, and every other line is ignored, until the winning line drops.

Each line also has a terminal-count pulse. When a pulse arrives, the block clears the enable bit of the matching line, so that line can make no further requests until software enables it again. Any terminal-count pulse also sets a sticky interrupt flag, which software clears with a strobe.

Top module: `dreq_lock_prioritizer`

## Requirements
- R1: After reset the enable register reads 0000, the merged request is low, the select code is 0 and the interrupt flag is low.
- R2: A write strobe loads all four enable bits from the write data. The new value is visible on the enable readback one cycle later.
- R3: A request line whose enable bit is 0 is ignored. With no enabled line asserted while idle, the merged request stays low.
- R4: When idle, the block picks the lowest-indexed asserted enabled line, and the merged request rises one cycle later. Bit 0 is channel A receive (code 0), bit 1 is channel B receive (code 1), bit 2 is channel A transmit (code 2) and bit 3 is channel B transmit (code 3).
- R5: While the merged request is high and the selected line stays asserted, the select code and the merged request hold. This is true even when a line of higher priority asserts.
- R6: One cycle after the selected line drops, the merged request is low. Pending enabled lines are evaluated in that idle cycle and win one cycle later.
- R7: A terminal-count pulse on bit k clears enable bit k one cycle later. If a write hits the same cycle, the clear wins for that bit.
- R8: Any terminal-count pulse sets the interrupt flag one cycle later. The flag stays set until it is cleared.
- R9: The clear strobe lowers the interrupt flag one cycle later, unless a terminal-count pulse arrives in the same cycle, in which case the flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_i | input | 4 | Raw DMA request lines (bit order as in R4) |
| en_wr_i | input | 1 | Enable register write strobe |
| en_wdata_i | input | 4 | Enable register write data |
| tc_i | input | 4 | Terminal-count pulses, one per line |
| irq_clr_i | input | 1 | Interrupt flag clear strobe |
| en_o | output | 4 | Enable register readback |
| dreq_o | output | 1 | Merged request toward the arbiter |
| sel_o | output | 2 | Arbitration vector select code |
| irq_o | output | 1 | Interrupt flag |

## Verification
Every combination of the four enable bits and the four request lines is applied from idle, 256 patterns in all. Each pattern's merged request and select code are compared with the lowest set bit of their AND. This separates gating faults from priority-order faults. Directed sequences then bring in a higher-priority line during a lock, to tell lockout from re-arbitration. They drop the winner while others pend, to show the one idle cycle, and they collide a terminal-count pulse with a register write and with an interrupt clear, to show which side wins each collision.

// File: rtl/dreq_lock_pkg.sv
package dreq_lock_pkg;
    localparam int NUM_SRC = 4;
    localparam int SEL_W   = $clog2(NUM_SRC);

    typedef logic [NUM_SRC-1:0] src_vec_t;
    typedef logic [SEL_W-1:0]   src_idx_t;

    typedef struct packed {
        logic     active;
        src_idx_t idx;
    } lock_state_t;

    // lowest set index wins; returns 0 for an empty vector
    function automatic src_idx_t pick_first(input src_vec_t v);
        src_idx_t r = '0;
        for (int i = NUM_SRC - 1; i >= 0; i--) begin
            if (v[i]) r = src_idx_t'(i);
        end
        return r;
    endfunction
endpackage

// File: rtl/dreq_enable_reg.sv
module dreq_enable_reg
    import dreq_lock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     wr_i,
    input  src_vec_t wdata_i,
    input  src_vec_t tc_i,
    output src_vec_t en_o
);
    for (genvar g = 0; g < NUM_SRC; g++) begin : g_bit
        logic bit_q;
        always_ff @(posedge clk) begin
            if (rst)          bit_q <= 1'b0;
            else if (tc_i[g]) bit_q <= 1'b0;
            else if (wr_i)    bit_q <= wdata_i[g];
        end
        assign en_o[g] = bit_q;
    end
endmodule

// File: rtl/dreq_lock_sel.sv
module dreq_lock_sel
    import dreq_lock_pkg::*;
(
    input  logic        clk,
    input  logic        rst,
    input  src_vec_t    req_i,
    input  src_vec_t    en_i,
    output lock_state_t st_o
);
    lock_state_t st_q, st_d;
    src_vec_t    pend;

    always_comb begin
        pend = req_i & en_i;
        st_d = st_q;
        if (st_q.active) begin
            if (!req_i[st_q.idx]) st_d.active = 1'b0;
        end else if (|pend) begin
            st_d.active = 1'b1;
            st_d.idx    = pick_first(pend);
        end
    end

    always_ff @(posedge clk) begin
        if (rst) st_q <= '0;
        else     st_q <= st_d;
    end

    assign st_o = st_q;
endmodule

// File: rtl/dreq_irq_flag.sv
module dreq_irq_flag
    import dreq_lock_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  src_vec_t tc_i,
    input  logic     clr_i,
    output logic     flag_o
);
    logic flag_q;
    always_ff @(posedge clk) begin
        if (rst)        flag_q <= 1'b0;
        else if (|tc_i) flag_q <= 1'b1;
        else if (clr_i) flag_q <= 1'b0;
    end
    assign flag_o = flag_q;
endmodule

// File: rtl/dreq_lock_prioritizer.sv
module dreq_lock_prioritizer
    import dreq_lock_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic [3:0] req_i,
    input  logic       en_wr_i,
    input  logic [3:0] en_wdata_i,
    input  logic [3:0] tc_i,
    input  logic       irq_clr_i,
    output logic [3:0] en_o,
    output logic       dreq_o,
    output logic [1:0] sel_o,
    output logic       irq_o
);
    src_vec_t    en_w;
    lock_state_t st_w;

    dreq_enable_reg u_en (
        .clk     (clk),
        .rst     (rst),
        .wr_i    (en_wr_i),
        .wdata_i (en_wdata_i),
        .tc_i    (tc_i),
        .en_o    (en_w)
    );

    dreq_lock_sel u_sel (
        .clk   (clk),
        .rst   (rst),
        .req_i (req_i),
        .en_i  (en_w),
        .st_o  (st_w)
    );

    dreq_irq_flag u_irq (
        .clk    (clk),
        .rst    (rst),
        .tc_i   (tc_i),
        .clr_i  (irq_clr_i),
        .flag_o (irq_o)
    );

    assign en_o   = en_w;
    assign dreq_o = st_w.active;
    assign sel_o  = st_w.idx;
endmodule

// File: rtl/dreq_lock_prioritizer_chk.sv
module dreq_lock_prioritizer_chk (
    input logic       clk,
    input logic       rst,
    input logic [3:0] req_i,
    input logic       en_wr_i,
    input logic [3:0] en_wdata_i,
    input logic [3:0] tc_i,
    input logic       irq_clr_i,
    input logic [3:0] en_o,
    input logic       dreq_o,
    input logic [1:0] sel_o,
    input logic       irq_o
);
    logic [3:0] pend_q;
    logic [3:0] low_mask;
    always_ff @(posedge clk) begin
        if (rst) pend_q <= '0;
        else     pend_q <= req_i & en_o;
    end
    assign low_mask = (4'd1 << sel_o) - 4'd1;

    // R3
    idle_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        (!dreq_o && ((req_i & en_o) == 4'd0)) |=> !dreq_o);
    // R4
    winner_lowest_chk: assert property (@(posedge clk) disable iff (rst)
        $rose(dreq_o) |-> (pend_q[sel_o] && ((pend_q & low_mask) == 4'd0)));
    // R5
    lock_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (dreq_o && req_i[sel_o]) |=> (dreq_o && $stable(sel_o)));
    // R6
    release_chk: assert property (@(posedge clk) disable iff (rst)
        (dreq_o && !req_i[sel_o]) |=> !dreq_o);
    // R7
    tc_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_i != 4'd0) |=> ((en_o & $past(tc_i)) == 4'd0));
    // R8
    irq_set_chk: assert property (@(posedge clk) disable iff (rst)
        (tc_i != 4'd0) |=> irq_o);
    // R9
    irq_clr_chk: assert property (@(posedge clk) disable iff (rst)
        (irq_clr_i && tc_i == 4'd0) |=> !irq_o);
endmodule

bind dreq_lock_prioritizer dreq_lock_prioritizer_chk u_chk (.*);

// File: tb/dreq_lock_prioritizer_tb.sv
module dreq_lock_prioritizer_tb;
    logic       clk = 1'b0;
    logic       rst;
    logic [3:0] req_i, en_wdata_i, tc_i, en_o;
    logic       en_wr_i, irq_clr_i, dreq_o, irq_o;
    logic [1:0] sel_o;
    int         n_vec = 0;
    int         n_bad = 0;
    bit         done = 0;

    always #2 clk = ~clk;

    dreq_lock_prioritizer u_dut (.*);

    task automatic step();
        @(posedge clk);
        #1;
    endtask

    task automatic chk(input string tag, input int act, input int exp);
        n_vec++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    function automatic int first_bit(input logic [3:0] v);
        for (int i = 0; i < 4; i++) if (v[i]) return i;
        return 0;
    endfunction

    task automatic write_en(input logic [3:0] v);
        en_wr_i = 1'b1; en_wdata_i = v;
        step();
        en_wr_i = 1'b0;
    endtask

    initial begin
        #(200000 * 4);
        if (!done) begin
            n_bad++;
            $display("FAIL watchdog actual=%0d expected=%0d", 0, 1);
            $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
            $finish;
        end
    end

    initial begin
        rst = 1'b1; req_i = '0; en_wr_i = 1'b0; en_wdata_i = '0;
        tc_i = '0; irq_clr_i = 1'b0;
        step(); step();
        rst = 1'b0;
        // R1 reset state
        chk("R1 en", en_o, 0);
        chk("R1 dreq", dreq_o, 0);
        chk("R1 sel", sel_o, 0);
        chk("R1 irq", irq_o, 0);

        // R2 R3 R4 exhaustive sweep of enable x request
        for (int e = 0; e < 16; e++) begin
            for (int r = 0; r < 16; r++) begin
                logic [3:0] pe;
                write_en(4'(e));
                chk("R2 en readback", en_o, e);
                req_i = 4'(r);
                step();
                pe = 4'(e) & 4'(r);
                chk("R3/R4 dreq", dreq_o, (pe != 0) ? 1 : 0);
                if (pe != 0) chk("R4 sel", sel_o, first_bit(pe));
                req_i = '0;
                step();
                step();
            end
        end

        // R5 lockout against a higher-priority newcomer
        write_en(4'hF);
        req_i = 4'b1000;
        step();
        chk("R5 first pick", sel_o, 3);
        req_i = 4'b1001;
        step(); step();
        chk("R5 sel held", sel_o, 3);
        chk("R5 dreq held", dreq_o, 1);
        // R6 release then re-evaluate
        req_i = 4'b0001;
        step();
        chk("R6 idle cycle", dreq_o, 0);
        step();
        chk("R6 relock", dreq_o, 1);
        chk("R6 new sel", sel_o, 0);
        req_i = '0;
        step(); step();

        // R7 terminal count clears its enable
        tc_i = 4'b0100;
        step();
        tc_i = '0;
        chk("R7 cleared", en_o, 4'b1011);
        chk("R8 irq set", irq_o, 1);
        req_i = 4'b0100;
        step();
        chk("R7 disabled line ignored", dreq_o, 0);
        req_i = '0;
        // R7 collision with write
        en_wr_i = 1'b1; en_wdata_i = 4'hF; tc_i = 4'b0001;
        step();
        en_wr_i = 1'b0; tc_i = '0;
        chk("R7 tc beats write", en_o, 4'b1110);
        // R8 sticky
        step(); step(); step();
        chk("R8 sticky", irq_o, 1);
        // R9 clear
        irq_clr_i = 1'b1;
        step();
        irq_clr_i = 1'b0;
        chk("R9 cleared", irq_o, 0);
        irq_clr_i = 1'b1; tc_i = 4'b1000;
        step();
        irq_clr_i = 1'b0; tc_i = '0;
        chk("R9 set beats clear", irq_o, 1);
        chk("R7 tx2 cleared", en_o, 4'b0110);
        irq_clr_i = 1'b1;
        step();
        irq_clr_i = 1'b0;
        chk("R9 cleared again", irq_o, 0);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
        $finish;
    end
endmodule